// File: doc/BRIEF.md
# Short-Packet Convolutional Decoder

This block takes one received coded voice packet, delivered as a serial bit stream, and returns the data bits it carries. Along with the data it reports how many channel bits it had to correct. On the transmit side each packet of 128 or 256 data bits is passed through a rate 1/2, constraint length 3 convolutional encoder. Two zero bits are appended so that the encoder ends in the all-zero state. The coded packet is then permuted across its whole length before it is sent. An error burst on the link therefore lands, after this block has undone the permutation, on coded bits that lie far apart.

The decoder first collects the whole coded packet and writes each bit to its coded position, which reverses the transmit permutation. It then steps a four-state trellis once per coded bit pair, using hard-decision Hamming branch metrics and 8-bit saturating path metrics that are renormalised at every step. Survivor decisions for every step are stored. A single traceback pass starts in state 0 at the terminated end of the trellis. This pass recovers the data bits, writes them into an output store so they leave in transmit order, and counts the places where the re-encoded path disagrees with what was received. The data bits then stream out one per cycle, with a last flag on the final bit.

Top module: `vit_decoder`

## Requirements
- R1: Coded bit k of a packet is defined as follows: bit 2t is the tap-7 (octal) output and bit 2t+1 is the tap-5 output for trellis step t. The received stream is interleaved with length L = 2(N+2). Received position p carries coded bit (31·p) mod L, and the decoder places it back there before decoding.
- R2: The code has rate 1/2 and constraint length 3, with generators 7 and 5 octal. It is terminated by two zero inputs. An error-free packet decodes to exactly the transmitted data bits, first data bit first.
- R3: With mode_long low a packet carries N = 128 data bits; with it high, N = 256. Each packet produces exactly N out_valid cycles in one unbroken run. out_last is high only on the N-th of them, and the two tail steps are never output.
- R4: Channel errors are corrected. This covers single errors at the first and last received positions, isolated errors, and a burst of 8 consecutive received bits.
- R5: corr_count equals the number of received coded bits that differ from the re-encoded decoded path. It is valid while out_last is high and does not change while out_valid is high.
- R6: Path metrics start with state 0 at zero and the other states at the ceiling. After every trellis step the smallest metric is zero.
- R7: The first bit of a packet is taken only when start and in_valid are high together. Cycles with in_valid low inside a packet are skipped. Start pulses and input bits that arrive while a packet is being decoded or output have no effect.
- R8: After reset out_valid, out_last and corr_count are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Marks the first bit of a packet, qualified by in_valid |
| in_valid | input | 1 | in_bit carries a received coded bit |
| in_bit | input | 1 | Received coded bit in transmission order |
| mode_long | input | 1 | 0: 128 data bits, 1: 256 data bits; sampled with the first bit |
| out_valid | output | 1 | out_bit carries a decoded data bit |
| out_bit | output | 1 | Decoded data bit, first data bit first |
| out_last | output | 1 | Final data bit of the packet |
| corr_count | output | 10 | Number of corrected channel bits for the packet |

## Verification
Two activities can fall in the same cycle. One is arrival of input: a new start marker together with a valid bit. The other is the decoder's own trellis work on the packet it has just finished collecting. The bench provokes this by driving start and in_valid for one cycle right after the last bit of a packet, when the first trellis step is running. It also fills some packets with random in_valid gaps. The outcome is judged by requiring the interrupted packet to still deliver every data bit, a correct last position and the exact correction count, and by checking that the next packet, begun properly, decodes cleanly. A second overlap sits at the trellis ends, where errors at the first and last received positions meet the forced start state and the forced end state.

// File: rtl/vit_pkg.sv
package vit_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RECV,
        PH_ACS,
        PH_TRACE,
        PH_EMIT
    } phase_e;

    // Coded pair for one transition: [1] = taps 111, [0] = taps 101.
    // prev[1] is the newer stored input, prev[0] the older one.
    function automatic logic [1:0] sym_of(input logic [1:0] prev, input logic u);
        return {u ^ prev[1] ^ prev[0], u ^ prev[0]};
    endfunction

endpackage

// File: rtl/vit_acs.sv
module vit_acs
    import vit_pkg::*;
#(
    parameter int MW = 8
) (
    input  logic [3:0][MW-1:0] pm_in,
    input  logic [1:0]         sym,
    output logic [3:0][MW-1:0] pm_out,
    output logic [3:0]         dec
);
    logic [3:0][MW-1:0] raw;
    logic [MW-1:0]      lo01, lo23, lo;

    for (genvar ns = 0; ns < 4; ns++) begin : g_state
        localparam int P0 = (ns % 2) * 2;
        localparam int P1 = P0 + 1;
        localparam logic U = 1'(ns / 2);
        logic [1:0]    miss0, miss1;
        logic [MW:0]   sum0, sum1;
        logic [MW-1:0] c0, c1;

        always_comb begin
            miss0 = sym_of(2'(P0), U) ^ sym;
            miss1 = sym_of(2'(P1), U) ^ sym;
            sum0  = {1'b0, pm_in[P0]} + (MW+1)'(miss0[0]) + (MW+1)'(miss0[1]);
            sum1  = {1'b0, pm_in[P1]} + (MW+1)'(miss1[0]) + (MW+1)'(miss1[1]);
            c0    = sum0[MW] ? '1 : sum0[MW-1:0];
            c1    = sum1[MW] ? '1 : sum1[MW-1:0];
            dec[ns] = (c1 < c0);
            raw[ns] = (c1 < c0) ? c1 : c0;
        end
    end

    always_comb begin
        lo01 = (raw[1] < raw[0]) ? raw[1] : raw[0];
        lo23 = (raw[3] < raw[2]) ? raw[3] : raw[2];
        lo   = (lo23 < lo01) ? lo23 : lo01;
        for (int s = 0; s < 4; s++) pm_out[s] = raw[s] - lo;
    end

endmodule

// File: rtl/vit_deint.sv
module vit_deint #(
    parameter int NLONG  = 256,
    parameter int STRIDE = 31
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         restart,
    input  logic                         wr_en,
    input  logic                         wr_bit,
    input  logic [$clog2(2*(NLONG+2))-1:0] len,
    input  logic [$clog2(NLONG+2)-1:0]   rd_step,
    output logic [1:0]                   rd_sym
);
    localparam int LMAX = 2 * (NLONG + 2);
    localparam int AW   = $clog2(LMAX);

    logic [LMAX-1:0] store_q;
    logic [AW-1:0]   addr_q, addr_d, wa;
    logic [AW:0]     nxt;
    logic [AW-1:0]   ra;

    always_comb begin
        wa     = restart ? '0 : addr_q;
        nxt    = {1'b0, wa} + (AW+1)'(STRIDE);
        if (nxt >= {1'b0, len}) nxt = nxt - {1'b0, len};
        addr_d = wr_en ? nxt[AW-1:0] : addr_q;
        ra     = AW'({rd_step, 1'b0});
        rd_sym = {store_q[ra], store_q[ra + AW'(1)]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) store_q[wa] <= wr_bit;
    end

endmodule

// File: rtl/vit_decoder.sv
module vit_decoder
    import vit_pkg::*;
#(
    parameter int NSHORT = 128,
    parameter int NLONG  = 256,
    parameter int STRIDE = 31,
    parameter int MW     = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       in_valid,
    input  logic       in_bit,
    input  logic       mode_long,
    output logic       out_valid,
    output logic       out_bit,
    output logic       out_last,
    output logic [$clog2(2*(NLONG+2)+1)-1:0] corr_count
);
    localparam int LMAX  = 2 * (NLONG + 2);
    localparam int STEPS = NLONG + 2;
    localparam int AW    = $clog2(LMAX);
    localparam int SW    = $clog2(STEPS);
    localparam int DW    = $clog2(NLONG);
    localparam int CW    = $clog2(LMAX + 1);

    typedef struct packed {
        phase_e             ph;
        logic               lng;
        logic [AW-1:0]      cnt;
        logic [SW-1:0]      step;
        logic [3:0][MW-1:0] pm;
        logic [1:0]         st;
        logic [CW-1:0]      corr;
        logic [DW-1:0]      oidx;
        logic               ov;
        logic               ob;
        logic               ol;
    } regs_t;

    regs_t r_q, r_d;

    logic [3:0]         dec_mem [STEPS];
    logic [NLONG-1:0]   data_mem;
    logic [3:0][MW-1:0] pm_new;
    logic [3:0]         dec_new;
    logic [1:0]         rd_sym, prev, miss;
    logic               wr_en, restart, dec_we, data_we;
    logic [AW-1:0]      pkt_len;
    logic [SW-1:0]      last_step;
    logic [DW-1:0]      last_idx;
    logic               acs_phase;
    logic [3:0][MW-1:0] pm_now;

    assign pkt_len   = r_q.lng ? AW'(2*(NLONG+2)) : AW'(2*(NSHORT+2));
    assign last_step = r_q.lng ? SW'(NLONG+1) : SW'(NSHORT+1);
    assign last_idx  = r_q.lng ? DW'(NLONG-1) : DW'(NSHORT-1);
    assign restart   = (r_q.ph == PH_IDLE);

    vit_deint #(.NLONG(NLONG), .STRIDE(STRIDE)) u_deint (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .wr_en   (wr_en),
        .wr_bit  (in_bit),
        .len     (restart ? (mode_long ? AW'(2*(NLONG+2)) : AW'(2*(NSHORT+2))) : pkt_len),
        .rd_step (r_q.step),
        .rd_sym  (rd_sym)
    );

    vit_acs #(.MW(MW)) u_acs (
        .pm_in  (r_q.pm),
        .sym    (rd_sym),
        .pm_out (pm_new),
        .dec    (dec_new)
    );

    always_comb begin
        r_d     = r_q;
        r_d.ov  = 1'b0;
        r_d.ol  = 1'b0;
        wr_en   = 1'b0;
        dec_we  = 1'b0;
        data_we = 1'b0;
        prev    = {r_q.st[0], dec_mem[r_q.step][r_q.st]};
        miss    = sym_of(prev, r_q.st[1]) ^ rd_sym;
        case (r_q.ph)
            PH_IDLE: if (in_valid && start) begin
                wr_en     = 1'b1;
                r_d.cnt   = AW'(1);
                r_d.lng   = mode_long;
                r_d.ph    = PH_RECV;
            end
            PH_RECV: if (in_valid) begin
                wr_en   = 1'b1;
                r_d.cnt = r_q.cnt + AW'(1);
                if (r_q.cnt == pkt_len - AW'(1)) begin
                    r_d.ph   = PH_ACS;
                    r_d.step = '0;
                    r_d.pm   = '1;
                    r_d.pm[0] = '0;
                end
            end
            PH_ACS: begin
                dec_we = 1'b1;
                r_d.pm = pm_new;
                if (r_q.step == last_step) begin
                    r_d.ph   = PH_TRACE;
                    r_d.st   = 2'b00;
                    r_d.corr = '0;
                end else begin
                    r_d.step = r_q.step + SW'(1);
                end
            end
            PH_TRACE: begin
                r_d.corr = r_q.corr + CW'(miss[0]) + CW'(miss[1]);
                data_we  = (r_q.step < last_step - SW'(1));
                r_d.st   = prev;
                if (r_q.step == '0) begin
                    r_d.ph   = PH_EMIT;
                    r_d.oidx = '0;
                end else begin
                    r_d.step = r_q.step - SW'(1);
                end
            end
            PH_EMIT: begin
                r_d.ov = 1'b1;
                r_d.ob = data_mem[r_q.oidx];
                r_d.ol = (r_q.oidx == last_idx);
                if (r_q.oidx == last_idx) r_d.ph = PH_IDLE;
                else                      r_d.oidx = r_q.oidx + DW'(1);
            end
            default: r_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.ph <= PH_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    always_ff @(posedge clk) begin
        if (dec_we)  dec_mem[r_q.step] <= dec_new;
        if (data_we) data_mem[r_q.step[DW-1:0]] <= r_q.st[1];
    end

    assign acs_phase  = (r_q.ph == PH_ACS);
    assign pm_now     = r_q.pm;
    assign out_valid  = r_q.ov;
    assign out_bit    = r_q.ob;
    assign out_last   = r_q.ol;
    assign corr_count = r_q.corr;

endmodule

// File: rtl/vit_decoder_chk.sv
module vit_decoder_chk #(
    parameter int MW = 8,
    parameter int CW = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               out_valid,
    input logic               out_last,
    input logic [CW-1:0]      corr_count,
    input logic               acs_phase,
    input logic [3:0][MW-1:0] pm_now
);
    // R3
    last_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R3
    run_unbroken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> $past(out_last));

    // R5
    corr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> $stable(corr_count));

    // R6
    renorm_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acs_phase |=> (pm_now[0] == '0 || pm_now[1] == '0 ||
                       pm_now[2] == '0 || pm_now[3] == '0));

    // R6
    metric_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acs_phase) |-> (pm_now[0] == '0 && pm_now[1] == '1 &&
                              pm_now[2] == '1 && pm_now[3] == '1));
endmodule

bind vit_decoder vit_decoder_chk #(.MW(MW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_last   (out_last),
    .corr_count (corr_count),
    .acs_phase  (acs_phase),
    .pm_now     (pm_now)
);

// File: tb/vit_decoder_test.sv
module vit_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int NL = 256;
    localparam int LM = 2 * (NL + 2);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_bit = 1'b0;
    logic       mode_long = 1'b0;
    logic       out_valid, out_bit, out_last;
    logic [9:0] corr_count;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    bit dat [NL];
    bit cod [LM];
    bit flp [LM];

    always #(CLK_PERIOD/2) clk = ~clk;

    vit_decoder uut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_bit(in_bit), .mode_long(mode_long), .out_valid(out_valid),
        .out_bit(out_bit), .out_last(out_last), .corr_count(corr_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Encoder with taps 7 and 5, two zero tail inputs (R1, R2)
    function automatic void encode(input int n);
        bit u1 = 0, u2 = 0;
        for (int t = 0; t < n + 2; t++) begin
            bit u = (t < n) ? dat[t] : 1'b0;
            cod[2*t]   = u ^ u1 ^ u2;
            cod[2*t+1] = u ^ u2;
            u2 = u1;
            u1 = u;
        end
    endfunction

    function automatic void clear_flips();
        for (int k = 0; k < LM; k++) flp[k] = 0;
    endfunction

    function automatic void fill_data(input int kind);
        for (int k = 0; k < NL; k++)
            dat[k] = (kind == 0) ? 1'b0 : (kind == 1) ? 1'b1 : 1'($urandom_range(1));
    endfunction

    task automatic run_packet(input bit lng, input int gap_pct, input bit poke,
                              input int exp_corr, input string name);
        int n = lng ? 256 : 128;
        int len = 2 * (n + 2);
        int got = 0, errs = 0, last_at = -1, corr = -1, waitc = 0;
        bit done = 0;
        encode(n);
        @(negedge clk);
        mode_long = lng;
        for (int p = 0; p < len; p++) begin
            while (p > 0 && gap_pct > 0 && $urandom_range(99) < gap_pct) begin
                in_valid = 0; start = 0; in_bit = 1'($urandom_range(1));
                @(negedge clk);
            end
            in_valid = 1;
            start    = (p == 0);
            in_bit   = cod[(p * 31) % len] ^ flp[p];
            @(negedge clk);
        end
        in_valid = 0; start = 0;
        if (poke) begin
            // R7: start with a valid bit while the first trellis step runs
            in_valid = 1; start = 1; in_bit = 1;
            @(negedge clk);
            in_valid = 0; start = 0;
        end
        while (!done && waitc < 4000) begin
            @(negedge clk);
            waitc++;
            if (out_valid) begin
                if (got < n && out_bit != dat[got]) errs++;
                if (out_last) begin
                    last_at = got;
                    corr = int'(corr_count);
                    done = 1;
                end
                got++;
            end
        end
        $display("packet %s: bits=%0d mismatches=%0d corr=%0d", name, got, errs, corr);
        check(errs == 0 && done, "R1 R2 R4 R7 data bits", errs, 0);
        check(got == n, "R3 bit count", got, n);
        check(last_at == n - 1, "R3 last position", last_at, n - 1);
        check(corr == exp_corr, "R5 correction count", corr, exp_corr);
    endtask

    initial begin
        void'($urandom(32'd2025));
        clear_flips();
        repeat (3) @(negedge clk);
        // R8: reset state
        check(out_valid == 0, "R8 out_valid after reset", int'(out_valid), 0);
        check(out_last == 0, "R8 out_last after reset", int'(out_last), 0);
        check(corr_count == 0, "R8 corr_count after reset", int'(corr_count), 0);
        rst_n = 1'b1;
        // R7: lone in_valid without start is ignored
        @(negedge clk); in_valid = 1; in_bit = 1;
        @(negedge clk); in_valid = 0;

        // R2 R3: short packet, all zeros, clean
        fill_data(0); clear_flips();
        run_packet(0, 0, 0, 0, "short_zero");

        // R2 R3: long packet, random, clean
        fill_data(2); clear_flips();
        run_packet(1, 0, 0, 0, "long_clean");

        // R4 R5: short packet with an 8-bit received burst
        begin
            int b0 = $urandom_range(2 * 130 - 8);
            fill_data(2); clear_flips();
            for (int k = 0; k < 8; k++) flp[b0 + k] = 1;
            run_packet(0, 0, 0, 8, "short_burst");
        end

        // R4: errors on the first and last received positions
        fill_data(2); clear_flips();
        flp[0] = 1; flp[2 * 258 - 1] = 1;
        run_packet(1, 0, 0, 2, "long_edges");

        // R7 R4: gaps, burst and a stray start while decoding
        begin
            int b0 = $urandom_range(2 * 258 - 8);
            fill_data(2); clear_flips();
            for (int k = 0; k < 8; k++) flp[b0 + k] = 1;
            run_packet(1, 30, 1, 8, "long_gaps_poke");
        end

        // R2 R4: short packet of ones, one isolated error
        fill_data(1); clear_flips();
        flp[$urandom_range(20, 240)] = 1;
        run_packet(0, 10, 0, 1, "short_ones");

        // R3: mode switch back to long after short
        fill_data(2); clear_flips();
        run_packet(1, 0, 1, 0, "long_after");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R3 watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule